// File: doc/BRIEF.md
# Ternary-Weight Zero-Skip Accumulator

This block forms a signed dot product between binary activations and ternary weights with no multiplier. Each weight is one of −1, 0 or +1 and simply chooses between subtracting the paired activation, adding it, or leaving the running sum alone. Work arrives as groups of eight weight/activation pairs over a valid/ready handshake. Inside a group, a lowest-index-first scanner jumps straight from one nonzero weight to the next. Zero weights therefore never occupy a cycle, and a group's latency depends only on how many nonzero weights it holds.

The running sum is kept in a 43-bit two's-complement register. That width covers the full 27-trit balanced range ±(3^27−1)/2, so no rescaling happens partway through a dot product. A clear pulse restarts the sum. A last-group flag on the final group of a dot product makes the block present the finished sum for one cycle. Two counters, one for executed operations and one for skipped weights, give a running view of how sparse the weights were.

Top module: `tern_dot_acc`

## Requirements
- R1: Each lane carries its weight in two bits of `in_wgt`: lane i sits at bits [2i+1:2i]. The code 2'b01 adds the lane's 16-bit signed activation (`in_act` bits [16i+15:16i]), 2'b10 subtracts it, and 2'b00 leaves the sum unchanged.
- R2: The code 2'b11 is treated exactly like 2'b00. Any accepted group containing it sets `bad_code`, which then stays high until reset; `clear` does not lower it.
- R3: A group with k nonzero weights takes k cycles. `in_ready` falls for k−1 cycles after acceptance, and a group with k of 0 or 1 leaves `in_ready` high on the next cycle.
- R4: A group is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever no accepted nonzero weight is still waiting.
- R5: The cycle after the last operation of a group flagged by `in_last` (or after acceptance of an all-zero flagged group), `res_valid` is high for exactly one cycle. In that cycle `res_data` holds the sum since the last clear; the sum itself is not reset by this.
- R6: `res_data` is 43-bit two's complement and does not wrap for any sum within ±(3^27−1)/2, including sums beyond the 32-bit range.
- R7: A `clear` pulse sets the running sum, `op_count` and `skip_count` to zero on the next cycle, taking priority over any operation in that cycle.
- R8: `op_count` rises by one for every nonzero weight executed. `skip_count` rises, on acceptance, by the number of lanes in the group whose code is 2'b00 or 2'b11.
- R9: After reset, `in_ready` is high, `res_valid` and `bad_code` are low, and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Zero the sum and both counters |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Block can take a group |
| in_last | input | 1 | Group ends the dot product |
| in_wgt | input | 16 | Eight 2-bit weight codes |
| in_act | input | 128 | Eight 16-bit signed activations |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 43 | Signed dot product |
| op_count | output | 32 | Executed nonzero weights |
| skip_count | output | 32 | Skipped zero or illegal weights |
| bad_code | output | 1 | Sticky illegal-code flag |

## Verification
The assertions assume that `clear` is only pulsed while the block is idle between dot products, so no sum is discarded by a clear. They also assume that `in_wgt`, `in_act` and `in_last` are stable while a group is being offered. The bench drives every group on a falling edge, holds it until the rising edge that accepts it, and issues `clear` only after a result has been observed and `in_ready` is high. Illegal codes appear only in one directed group.

// File: rtl/tern_dot_acc.sv
module tern_dot_acc #(
  parameter int LANES = 8,
  parameter int ACT_W = 16,
  parameter int ACC_W = 43,
  parameter int CNT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_last,
  input  logic [2*LANES-1:0]      in_wgt,
  input  logic [LANES*ACT_W-1:0]  in_act,
  output logic                    res_valid,
  output logic [ACC_W-1:0]        res_data,
  output logic [CNT_W-1:0]        op_count,
  output logic [CNT_W-1:0]        skip_count,
  output logic                    bad_code
);

  logic                    busy, last_q;
  logic [LANES-1:0]        pend;
  logic [2*LANES-1:0]      wgt_q;
  logic [LANES*ACT_W-1:0]  act_q;
  logic signed [ACC_W-1:0] acc;

  logic [LANES-1:0]        nz_in, bad_in, src_mask, remain;
  logic [2*LANES-1:0]      src_w;
  logic [LANES*ACT_W-1:0]  src_a;
  logic [CNT_W-1:0]        zcnt;
  logic signed [ACT_W-1:0] act_sel;
  logic signed [ACC_W-1:0] act_ext, acc_nxt;
  logic                    neg, take, fire, finish, src_last;

  assign in_ready = !busy;
  assign take     = in_valid && !busy;

  always_comb begin
    zcnt = '0;
    for (int i = 0; i < LANES; i++) begin
      nz_in[i]  = in_wgt[2*i] ^ in_wgt[2*i+1];
      bad_in[i] = in_wgt[2*i] & in_wgt[2*i+1];
      zcnt      = zcnt + CNT_W'(!nz_in[i]);
    end
  end

  assign src_mask = busy ? pend : (take ? nz_in : '0);
  assign src_w    = busy ? wgt_q : in_wgt;
  assign src_a    = busy ? act_q : in_act;
  assign src_last = busy ? last_q : in_last;
  assign remain   = src_mask & (src_mask - 1'b1);
  assign fire     = |src_mask;
  assign finish   = (busy || take) && !(|remain) && src_last;

  always_comb begin
    act_sel = '0;
    neg     = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (src_mask[i]) begin
        act_sel = src_a[i*ACT_W +: ACT_W];
        neg     = src_w[2*i+1];
      end
    end
  end

  assign act_ext = ACC_W'(act_sel);
  assign acc_nxt = !fire ? acc : (neg ? acc - act_ext : acc + act_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend       <= '0;
      wgt_q      <= '0;
      act_q      <= '0;
      last_q     <= 1'b0;
      acc        <= '0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      op_count   <= '0;
      skip_count <= '0;
      bad_code   <= 1'b0;
    end else begin
      busy      <= |remain;
      pend      <= remain;
      res_valid <= finish;
      if (finish) res_data <= acc_nxt;
      if (take) begin
        wgt_q  <= in_wgt;
        act_q  <= in_act;
        last_q <= in_last;
        if (|bad_in) bad_code <= 1'b1;
      end
      if (clear) begin
        acc        <= '0;
        op_count   <= '0;
        skip_count <= '0;
      end else begin
        acc      <= acc_nxt;
        op_count <= op_count + CNT_W'(fire);
        if (take) skip_count <= skip_count + zcnt;
      end
    end
  end

endmodule

// File: rtl/tern_dot_acc_chk.sv
module tern_dot_acc_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             in_valid,
  input logic             in_ready,
  input logic             res_valid,
  input logic [CNT_W-1:0] op_count,
  input logic [CNT_W-1:0] skip_count,
  input logic             bad_code
);

  a_r2_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |=> bad_code);

  a_r3_busy_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !clear) |=> op_count == CNT_W'($past(op_count) + 1'b1));

  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (op_count == '0 && skip_count == '0));

  a_r8_skip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !clear) |=> $stable(skip_count));

  a_r8_op_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (op_count == $past(op_count) ||
                op_count == CNT_W'($past(op_count) + 1'b1)));

  a_r5_res_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && in_ready) |=> !res_valid);

endmodule

bind tern_dot_acc tern_dot_acc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
  .in_ready(in_ready), .res_valid(res_valid), .op_count(op_count),
  .skip_count(skip_count), .bad_code(bad_code)
);

// File: tb/tern_dot_acc_tb.sv
module tern_dot_acc_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_last = 1'b0;
  logic [15:0]  in_wgt = '0;
  logic [127:0] in_act = '0;
  logic         in_ready, res_valid, bad_code;
  logic [42:0]  res_data;
  logic [31:0]  op_count, skip_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  longint ref_acc = 0, ref_ops = 0, ref_skip = 0;

  always #5 clk = ~clk;

  tern_dot_acc u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_ready(in_ready), .in_last(in_last), .in_wgt(in_wgt), .in_act(in_act),
    .res_valid(res_valid), .res_data(res_data), .op_count(op_count),
    .skip_count(skip_count), .bad_code(bad_code)
  );

  typedef struct packed {
    logic [15:0]  w;
    logic [127:0] a;
    logic         l;
    logic [3:0]   k;
  } vec_t;

  localparam vec_t TBL [0:7] = '{
    '{16'h5555, {16'd8, 16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1}, 1'b0, 4'd8},
    '{16'hAAAA, {8{16'd100}}, 1'b1, 4'd8},
    '{16'h0000, {8{16'd77}}, 1'b0, 4'd0},
    '{16'h0001, {8{16'h8000}}, 1'b1, 4'd1},
    '{16'h8421, {16'hFFFB, 16'd9, 16'd3, 16'hFFF9, 16'd11, 16'd2, 16'd6, 16'd4}, 1'b0, 4'd4},
    '{16'h4000, {16'd1234, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd9}, 1'b1, 4'd1},
    '{16'h0000, {8{16'hFFFF}}, 1'b1, 4'd0},
    '{16'h9669, {8{16'h7FFF}}, 1'b1, 4'd8}
  };

  function automatic longint dot(input logic [15:0] w, input logic [127:0] a);
    longint s = 0;
    for (int i = 0; i < 8; i++) begin
      if (w[2*i +: 2] == 2'b01) s += longint'($signed(a[16*i +: 16]));
      else if (w[2*i +: 2] == 2'b10) s -= longint'($signed(a[16*i +: 16]));
    end
    return s;
  endfunction

  function automatic int nzc(input logic [15:0] w);
    int n = 0;
    for (int i = 0; i < 8; i++)
      if (w[2*i +: 2] == 2'b01 || w[2*i +: 2] == 2'b10) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    ref_acc = 0; ref_ops = 0; ref_skip = 0;
    check(op_count == 0 && skip_count == 0, "R7 counters cleared", op_count + skip_count, 0);
  endtask

  task automatic send(input logic [15:0] w, input logic [127:0] a, input bit l,
                      input int kexp, input bit full);
    int n, k;
    k = nzc(w);
    @(negedge clk);
    in_valid = 1'b1; in_wgt = w; in_act = a; in_last = l;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!in_ready) begin n++; @(negedge clk); end
    ref_acc += dot(w, a);
    ref_ops += k;
    ref_skip += 8 - k;
    if (full) begin
      check(k == kexp, "R1 table weight count", k, kexp);
      check(n == ((k > 0) ? k - 1 : 0), "R3 busy cycles", n, (k > 0) ? k - 1 : 0);
    end
    if (l) begin
      check(res_valid == 1'b1, "R5 result strobe", res_valid, 1);
      check(longint'($signed(res_data)) == ref_acc, "R1 R6 result value",
            longint'($signed(res_data)), ref_acc);
      @(negedge clk);
      check(res_valid == 1'b0, "R5 one-cycle strobe", res_valid, 0);
      check(op_count == ref_ops, "R8 op_count", op_count, ref_ops);
      check(skip_count == ref_skip, "R8 skip_count", skip_count, ref_skip);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    check(res_valid == 1'b0 && bad_code == 1'b0, "R9 flags after reset", res_valid + bad_code, 0);
    check(op_count == 0 && skip_count == 0, "R9 counters after reset", op_count + skip_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R4 idle ready", in_ready, 1);

    for (int i = 0; i < 8; i++) begin
      send(TBL[i].w, TBL[i].a, TBL[i].l, int'(TBL[i].k), 1'b1);
      if (TBL[i].l) do_clear();
    end

    // R2: lanes 0 and 1 carry 2'b11, lane 2 carries +1
    send(16'h001F, {16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd321, 16'd500, 16'd600}, 1'b1, 1, 1'b1);
    check(bad_code == 1'b1, "R2 illegal code flagged", bad_code, 1);
    do_clear();
    check(bad_code == 1'b1, "R2 flag survives clear", bad_code, 1);

    // R7: clear between groups drops a partial sum
    send(16'h5555, {8{16'd50}}, 1'b0, 8, 1'b1);
    do_clear();
    send(16'h0000, {8{16'd1}}, 1'b1, 0, 1'b1);
    check(res_data == 43'd0, "R7 sum cleared", longint'($signed(res_data)), 0);
    do_clear();

    // R3 R8: random groups with about 40 percent zero weights
    for (int g = 0; g < 60; g++) begin
      logic [15:0] w;
      logic [127:0] a;
      int r;
      for (int i = 0; i < 8; i++) begin
        r = $urandom % 10;
        w[2*i +: 2] = (r < 4) ? 2'b00 : ((r < 7) ? 2'b01 : 2'b10);
        a[16*i +: 16] = 16'($urandom);
      end
      if (g % 7 == 3) w = 16'h0000;
      if (g % 7 == 5) w = 16'h6A59;
      send(w, a, (g % 5 == 4), nzc(w), 1'b1);
      if (g % 5 == 4) do_clear();
    end

    // R6: sum beyond 32 bits, 65600 subtractions of -32768
    for (int g = 0; g < 8200; g++)
      send(16'hAAAA, {8{16'h8000}}, (g == 8199), 8, 1'b0);
    check(ref_acc == 64'd2149580800, "R6 reference magnitude", ref_acc, 64'd2149580800);
    do_clear();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule